// File: doc/BRIEF.md
# Packed Signed Saturating Add/Subtract Unit

This block is an execute-stage datapath for packed signed arithmetic with saturation. It takes two 32-bit operands and an instruction word. It treats the operands either as a pair of 16-bit signed lanes or as four 8-bit signed lanes, and it adds or subtracts them lane by lane. Any lane result that would leave its signed range is clamped to the lane's most positive or most negative value.

A 3-bit field of the instruction word picks one of six operations:

- plain 16-bit add;
- plain 16-bit subtract;
- two exchanged 16-bit forms, in which each half of the first operand is combined with the opposite half of the second operand;
- 8-bit add;
- 8-bit subtract.

Overflow is found only from the sign bits of the operands and of the wrapped result.

The unit is issued with a strobe. One cycle later it presents the packed result, the destination register index and a write-enable, ready for a register file write port. It also decodes the two source register indices straight from the instruction word, so the register file can be read. A condition-pass input from outside qualifies the write unless the instruction's condition field means "always". The two reserved selector codes never write, and they raise a one-cycle illegal-operation pulse.

Top module: `psat_unit`

## Requirements
- R1: Selector insn[7:5]=0 writes {sat16(a[31:16]+b[31:16]), sat16(a[15:0]+b[15:0])}, with the low lane in result bits 15:0 and the high lane in bits 31:16.
- R2: Selector 3 writes {sat16(a[31:16]-b[31:16]), sat16(a[15:0]-b[15:0])}.
- R3: Selector 1 writes low lane = sat16(a[15:0]-b[31:16]) and high lane = sat16(a[31:16]+b[15:0]).
- R4: Selector 2 writes low lane = sat16(a[15:0]+b[31:16]) and high lane = sat16(a[31:16]-b[15:0]).
- R5: Selector 4 writes four byte lanes, each sat8(a byte + b byte), every byte result staying in its own byte position.
- R6: Selector 7 writes four byte lanes, each sat8(a byte - b byte), every byte result staying in its own byte position.
- R7: A lane result that overflows is clamped by the sign of the first operand. A negative first operand gives 0x8000 or 0x80; otherwise the result is 0x7FFF or 0x7F. This covers subtracting the most negative value.
- R8: An operation is in this group only when insn[27:20]=0x62. Outside the group the unit asserts neither wr_en_o nor illegal_o. dest_o is taken from insn[15:12]. The outputs src_a_idx_o and src_b_idx_o show insn[19:16] and insn[3:0] combinationally.
- R9: When insn[31:28]=0xE the unit writes whatever the value of cond_pass_i. Any other condition value writes only when cond_pass_i is 1.
- R10: Selectors 5 and 6 within the group never assert wr_en_o. They assert illegal_o for exactly the one cycle after the issue.
- R11: result_o, dest_o, wr_en_o and illegal_o appear one clock after the cycle in which issue_i is 1. With issue_i at 0, wr_en_o and illegal_o are 0 in the next cycle. Reset clears wr_en_o and illegal_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Issue strobe for the current instruction |
| insn_i | input | 32 | Instruction word |
| cond_pass_i | input | 1 | Result of the external condition evaluation |
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Second operand |
| src_a_idx_o | output | 4 | First source register index (combinational) |
| src_b_idx_o | output | 4 | Second source register index (combinational) |
| result_o | output | 32 | Registered packed result |
| dest_o | output | 4 | Registered destination register index |
| wr_en_o | output | 1 | Registered write-enable |
| illegal_o | output | 1 | One-cycle pulse for a reserved selector |

## Verification
A table of vectors, each with a hand-computed result, drives every selector. It uses small values that do not saturate, so any swap of lanes, exchange of halves or add/subtract polarity shows at once. It also uses values that overflow in both directions, including 0x8000 and 0x80 used as the subtrahend, to tell a correct sign-based clamp from a wrapped result or a clamp with the wrong sign. Several hundred random operands are then compared against wide-integer arithmetic clamped to the lane range. Directed cases vary the group code, the condition field, the condition-pass input, the reserved selectors and an idle issue strobe, which separates the write qualification from the arithmetic itself.

// File: rtl/psat_pkg.sv
package psat_pkg;
  localparam int DATA_W  = 32;
  localparam int HALF_W  = DATA_W / 2;
  localparam int BYTE_W  = 8;
  localparam int N_HALF  = DATA_W / HALF_W;
  localparam int N_BYTE  = DATA_W / BYTE_W;
  localparam int IDX_W   = 4;
  localparam int SEL_W   = 3;

  localparam logic [7:0]       GROUP_CODE  = 8'h62;
  localparam logic [3:0]       COND_ALWAYS = 4'hE;

  typedef enum logic [SEL_W-1:0] {
    OP_HADD  = 3'd0,
    OP_HXSA  = 3'd1,
    OP_HXAS  = 3'd2,
    OP_HSUB  = 3'd3,
    OP_BADD  = 3'd4,
    OP_RSV5  = 3'd5,
    OP_RSV6  = 3'd6,
    OP_BSUB  = 3'd7
  } op_sel_e;
endpackage

// File: rtl/psat_rst_sync.sv
module psat_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/psat_decode.sv
module psat_decode
  import psat_pkg::*;
(
  input  logic [DATA_W-1:0] insn_i,
  input  logic              cond_pass_i,
  output op_sel_e           sel_o,
  output logic [IDX_W-1:0]  dest_o,
  output logic [IDX_W-1:0]  src_a_o,
  output logic [IDX_W-1:0]  src_b_o,
  output logic              write_ok_o,
  output logic              illegal_o
);
  logic group_hit;
  logic reserved;
  logic cond_ok;

  always_comb begin
    sel_o     = op_sel_e'(insn_i[7:5]);
    dest_o    = insn_i[15:12];
    src_a_o   = insn_i[19:16];
    src_b_o   = insn_i[3:0];
    group_hit = (insn_i[27:20] == GROUP_CODE);
    reserved  = (sel_o == OP_RSV5) || (sel_o == OP_RSV6);
    cond_ok   = (insn_i[31:28] == COND_ALWAYS) || cond_pass_i;
    write_ok_o = group_hit && !reserved && cond_ok;
    illegal_o  = group_hit && reserved;
  end
endmodule

// File: rtl/psat_lane.sv
module psat_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] y_o
);
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MAX_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] b_eff;
  logic [W-1:0] raw;
  logic         sign_rule;
  logic         ovf;

  always_comb begin
    b_eff     = sub_i ? ~b_i : b_i;
    raw       = a_i + b_eff + {{(W-1){1'b0}}, sub_i};
    sign_rule = sub_i ? (a_i[W-1] != b_i[W-1]) : (a_i[W-1] == b_i[W-1]);
    ovf       = sign_rule && (raw[W-1] != a_i[W-1]);
    if (ovf) y_o = a_i[W-1] ? MAX_NEG : MAX_POS;
    else     y_o = raw;
  end
endmodule

// File: rtl/psat_datapath.sv
module psat_datapath
  import psat_pkg::*;
(
  input  op_sel_e           sel_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o
);
  logic [DATA_W-1:0] half_res;
  logic [DATA_W-1:0] byte_res;
  logic              exchange;

  assign exchange = (sel_i == OP_HXSA) || (sel_i == OP_HXAS);

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    logic [HALF_W-1:0] b_pick;
    logic              sub_h;

    always_comb begin
      b_pick = exchange ? b_i[(N_HALF-1-h)*HALF_W +: HALF_W]
                        : b_i[h*HALF_W +: HALF_W];
      case (sel_i)
        OP_HSUB: sub_h = 1'b1;
        OP_HXSA: sub_h = (h == 0);
        OP_HXAS: sub_h = (h != 0);
        default: sub_h = 1'b0;
      endcase
    end

    psat_lane #(.W(HALF_W)) lane_i (
      .a_i   (a_i[h*HALF_W +: HALF_W]),
      .b_i   (b_pick),
      .sub_i (sub_h),
      .y_o   (half_res[h*HALF_W +: HALF_W])
    );
  end

  for (genvar k = 0; k < N_BYTE; k++) begin : g_byte
    psat_lane #(.W(BYTE_W)) lane_i (
      .a_i   (a_i[k*BYTE_W +: BYTE_W]),
      .b_i   (b_i[k*BYTE_W +: BYTE_W]),
      .sub_i (sel_i == OP_BSUB),
      .y_o   (byte_res[k*BYTE_W +: BYTE_W])
    );
  end

  always_comb begin
    y_o = sel_i[SEL_W-1] ? byte_res : half_res;
  end
endmodule

// File: rtl/psat_unit.sv
module psat_unit
  import psat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [DATA_W-1:0] insn_i,
  input  logic              cond_pass_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  output logic [IDX_W-1:0]  src_a_idx_o,
  output logic [IDX_W-1:0]  src_b_idx_o,
  output logic [DATA_W-1:0] result_o,
  output logic [IDX_W-1:0]  dest_o,
  output logic              wr_en_o,
  output logic              illegal_o
);
  logic              rst_sync_n;
  op_sel_e           sel;
  logic [IDX_W-1:0]  dec_dest;
  logic              dec_write_ok;
  logic              dec_illegal;
  logic [DATA_W-1:0] dp_res;

  logic              wr_d, wr_q;
  logic              ill_d, ill_q;
  logic [DATA_W-1:0] res_q;
  logic [IDX_W-1:0]  dest_q;
  logic              data_en;

  psat_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  psat_decode dec_i (
    .insn_i      (insn_i),
    .cond_pass_i (cond_pass_i),
    .sel_o       (sel),
    .dest_o      (dec_dest),
    .src_a_o     (src_a_idx_o),
    .src_b_o     (src_b_idx_o),
    .write_ok_o  (dec_write_ok),
    .illegal_o   (dec_illegal)
  );

  psat_datapath dp_i (
    .sel_i (sel),
    .a_i   (op_a_i),
    .b_i   (op_b_i),
    .y_o   (dp_res)
  );

  always_comb begin
    wr_d    = issue_i && dec_write_ok;
    ill_d   = issue_i && dec_illegal;
    data_en = issue_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wr_q  <= 1'b0;
      ill_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      ill_q <= ill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) begin
      res_q  <= dp_res;
      dest_q <= dec_dest;
    end
  end

  assign result_o  = res_q;
  assign dest_o    = dest_q;
  assign wr_en_o   = wr_q;
  assign illegal_o = ill_q;
endmodule

// File: rtl/psat_unit_chk.sv
module psat_unit_chk (
  input logic        clk,
  input logic        rst_ok,
  input logic        issue_i,
  input logic [31:0] insn_i,
  input logic        cond_pass_i,
  input logic [31:0] op_a_i,
  input logic [31:0] op_b_i,
  input logic [31:0] result_o,
  input logic [3:0]  dest_o,
  input logic        wr_en_o,
  input logic        illegal_o
);
  // R11
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !issue_i |=> (!wr_en_o && !illegal_o));

  // R10
  rsvd_no_write_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (issue_i && insn_i[27:20] == 8'h62 && (insn_i[7:5] == 3'd5 || insn_i[7:5] == 3'd6))
    |=> (illegal_o && !wr_en_o));

  // R8
  wrong_group_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (issue_i && insn_i[27:20] != 8'h62) |=> (!wr_en_o && !illegal_o));

  // R8
  dest_follow_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    issue_i |=> (dest_o == $past(insn_i[15:12])));

  // R9
  cond_fail_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (issue_i && insn_i[31:28] != 4'hE && !cond_pass_i) |=> !wr_en_o);

  // R2
  self_sub_zero_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (issue_i && insn_i[7:5] == 3'd3 && op_a_i == op_b_i) |=> (result_o == 32'h0));
endmodule

bind psat_unit psat_unit_chk chk_i (
  .clk         (clk),
  .rst_ok      (rst_sync_n),
  .issue_i     (issue_i),
  .insn_i      (insn_i),
  .cond_pass_i (cond_pass_i),
  .op_a_i      (op_a_i),
  .op_b_i      (op_b_i),
  .result_o    (result_o),
  .dest_o      (dest_o),
  .wr_en_o     (wr_en_o),
  .illegal_o   (illegal_o)
);

// File: tb/psat_unit_tb_top.sv
module psat_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  localparam logic [2:0] T_SEL [NVEC] = '{3'd0, 3'd0, 3'd3, 3'd3, 3'd1, 3'd1,
                                          3'd2, 3'd2, 3'd4, 3'd4, 3'd7, 3'd7};
  localparam logic [31:0] T_A [NVEC] = '{32'h0001_0002, 32'h7FFF_8000, 32'h0010_0010, 32'h0000_8000,
                                         32'h1234_8000, 32'h0000_0000, 32'h8000_8000, 32'h7FFF_7FFF,
                                         32'h0102_0304, 32'h7F80_10F0, 32'h0505_0505, 32'h0080_7F05};
  localparam logic [31:0] T_B [NVEC] = '{32'h0003_0004, 32'h0001_FFFF, 32'h0001_0020, 32'h8000_0001,
                                         32'h0001_0005, 32'h8000_0000, 32'h0001_0001, 32'h0001_FFFF,
                                         32'h0101_0101, 32'h01FF_20F0, 32'h0102_0304, 32'h8001_FF07};
  localparam logic [31:0] T_X [NVEC] = '{32'h0004_0006, 32'h7FFF_8000, 32'h000F_FFF0, 32'h7FFF_8000,
                                         32'h1239_8000, 32'h0000_7FFF, 32'h8000_8001, 32'h7FFF_7FFF,
                                         32'h0203_0405, 32'h7F80_30E0, 32'h0403_0201, 32'h7F80_7FFE};

  logic        clk;
  logic        rst_n;
  logic        issue;
  logic [31:0] insn;
  logic        cond_pass;
  logic [31:0] opa, opb;
  logic [3:0]  src_a, src_b;
  logic [31:0] result;
  logic [3:0]  dest;
  logic        wr_en;
  logic        illegal;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  psat_unit dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_i     (issue),
    .insn_i      (insn),
    .cond_pass_i (cond_pass),
    .op_a_i      (opa),
    .op_b_i      (opb),
    .src_a_idx_o (src_a),
    .src_b_idx_o (src_b),
    .result_o    (result),
    .dest_o      (dest),
    .wr_en_o     (wr_en),
    .illegal_o   (illegal)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] sat16(input logic [15:0] x, input logic [15:0] y, input bit sub);
    int r;
    r = sub ? (int'($signed(x)) - int'($signed(y))) : (int'($signed(x)) + int'($signed(y)));
    if (r > 32767) r = 32767;
    else if (r < -32768) r = -32768;
    return r[15:0];
  endfunction

  function automatic logic [7:0] sat8(input logic [7:0] x, input logic [7:0] y, input bit sub);
    int r;
    r = sub ? (int'($signed(x)) - int'($signed(y))) : (int'($signed(x)) + int'($signed(y)));
    if (r > 127) r = 127;
    else if (r < -128) r = -128;
    return r[7:0];
  endfunction

  function automatic logic [31:0] model(input logic [2:0] sel, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] y;
    case (sel)
      3'd0: y = {sat16(a[31:16], b[31:16], 0), sat16(a[15:0], b[15:0], 0)};
      3'd3: y = {sat16(a[31:16], b[31:16], 1), sat16(a[15:0], b[15:0], 1)};
      3'd1: y = {sat16(a[31:16], b[15:0], 0), sat16(a[15:0], b[31:16], 1)};
      3'd2: y = {sat16(a[31:16], b[15:0], 1), sat16(a[15:0], b[31:16], 0)};
      default: begin
        for (int k = 0; k < 4; k++)
          y[k*8 +: 8] = sat8(a[k*8 +: 8], b[k*8 +: 8], sel == 3'd7);
      end
    endcase
    return y;
  endfunction

  function automatic string tag_of(input logic [2:0] sel);
    case (sel)
      3'd0: return "R1";
      3'd3: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue_op(input logic [3:0] cnd, input logic [7:0] grp, input logic [2:0] sel,
                          input logic [31:0] a, input logic [31:0] b, input logic pass,
                          input logic [3:0] rd);
    @(negedge clk);
    insn      = {cnd, grp, 4'h3, rd, 4'h0, sel, 1'b1, 4'h9};
    opa       = a;
    opb       = b;
    cond_pass = pass;
    issue     = 1'b1;
    @(negedge clk);
    issue     = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; issue = 1'b0; insn = '0; cond_pass = 1'b0; opa = '0; opb = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset wr_en", {31'b0, wr_en}, 32'h0);
    check("R11 reset illegal", {31'b0, illegal}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 after release wr_en", {31'b0, wr_en}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      issue_op(4'hE, 8'h62, T_SEL[i], T_A[i], T_B[i], 1'b0, 4'(i));
      check(tag_of(T_SEL[i]), result, T_X[i]);
      check({tag_of(T_SEL[i]), " wr_en"}, {31'b0, wr_en}, 32'h1);
    end

    // R7 clamps toward most negative when first operand negative
    issue_op(4'hE, 8'h62, 3'd3, 32'h8000_8000, 32'h7FFF_0001, 1'b0, 4'h1);
    check("R7 half negative clamp", result, 32'h8000_8000);
    issue_op(4'hE, 8'h62, 3'd7, 32'h8080_8080, 32'h7F01_0080, 1'b0, 4'h1);
    check("R7 byte negative clamp", result, 32'h8080_8000);
    issue_op(4'hE, 8'h62, 3'd3, 32'h0001_0000, 32'h8000_8000, 1'b0, 4'h1);
    check("R7 minus most negative", result, 32'h7FFF_7FFF);
    issue_op(4'hE, 8'h62, 3'd7, 32'h0000_0000, 32'h8080_8080, 1'b0, 4'h1);
    check("R7 byte minus most negative", result, 32'h7F7F_7F7F);

    // R8 decode and source indices
    @(negedge clk);
    insn = 32'hE62A_5F19;
    #1;
    check("R8 src_a", {28'b0, src_a}, 32'hA);
    check("R8 src_b", {28'b0, src_b}, 32'h9);
    issue_op(4'hE, 8'h62, 3'd0, 32'h1, 32'h1, 1'b0, 4'hC);
    check("R8 dest", {28'b0, dest}, 32'hC);
    issue_op(4'hE, 8'h63, 3'd0, 32'h1, 32'h1, 1'b1, 4'h2);
    check("R8 other group wr_en", {31'b0, wr_en}, 32'h0);
    check("R8 other group illegal", {31'b0, illegal}, 32'h0);

    // R9 condition qualification
    issue_op(4'h0, 8'h62, 3'd0, 32'h1, 32'h1, 1'b0, 4'h2);
    check("R9 cond fail", {31'b0, wr_en}, 32'h0);
    issue_op(4'h0, 8'h62, 3'd0, 32'h1, 32'h1, 1'b1, 4'h2);
    check("R9 cond pass", {31'b0, wr_en}, 32'h1);
    issue_op(4'hE, 8'h62, 3'd0, 32'h1, 32'h1, 1'b0, 4'h2);
    check("R9 always", {31'b0, wr_en}, 32'h1);

    // R10 reserved selectors
    for (int s = 5; s <= 6; s++) begin
      issue_op(4'hE, 8'h62, 3'(s), 32'h1, 32'h1, 1'b1, 4'h2);
      check("R10 reserved wr_en", {31'b0, wr_en}, 32'h0);
      check("R10 reserved illegal", {31'b0, illegal}, 32'h1);
      @(negedge clk);
      check("R10 illegal one cycle", {31'b0, illegal}, 32'h0);
    end

    // R11 one-cycle latency, idle strobe
    issue_op(4'hE, 8'h62, 3'd0, 32'h0002_0002, 32'h0001_0001, 1'b0, 4'h4);
    check("R11 latency result", result, 32'h0003_0003);
    @(negedge clk);
    check("R11 idle wr_en", {31'b0, wr_en}, 32'h0);

    // random operands against the wide model
    for (int n = 0; n < 300; n++) begin
      logic [2:0]  sel;
      logic [31:0] a, b;
      sel = 3'($urandom_range(0, 5));
      if (sel == 3'd5) sel = 3'd7;
      a = $urandom;
      b = $urandom;
      if (n % 7 == 0) b = (sel[2]) ? 32'h8080_8080 : 32'h8000_8000;
      issue_op(4'hE, 8'h62, sel, a, b, 1'b0, 4'h5);
      check({tag_of(sel), " random"}, result, model(sel, a, b));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule